// File: doc/BRIEF.md
# Bidirectional 40-bit Barrel Shifter

The block shifts one operand by a signed count in a single pass through a 40-bit datapath. The operand comes from one of two 40-bit accumulator inputs or from a 16-bit bus word. The sign of the count sets the direction and its magnitude sets the distance, which is at most 16 places either way. Right shifts fill from the top either with copies of the sign bit or with zeros, as selected. Left shifts always fill from the bottom with zeros.

A bus word does not enter the datapath at a fixed place. For a right shift it is placed in the window at bits 16..31, so the bits it shifts out drop below the window. For a left shift it is placed at bits 0..15. The 16-bit result is read back from the same window the word was placed in. Both results are registered, so they appear on the clock edge after the inputs are presented. Status flags and the write-back of the result are left to the surrounding datapath.

Top module: `shbt_barrel`

## Requirements
- R1: While rst_n is low, acc_out and word_out are zero.
- R2: Results are registered. Inputs present before a rising clock edge determine both outputs after that edge.
- R3: A positive shift_cnt shifts the operand right by that many places.
- R4: A negative shift_cnt shifts the operand left by its magnitude, and zeros enter at bit 0.
- R5: A zero shift_cnt passes the operand through unchanged. For a word source, word_out equals word_in.
- R6: For right shifts, arith_right=1 fills from the top with the operand's sign bit and arith_right=0 fills with zeros. For left shifts arith_right has no effect.
- R7: shift_cnt is a 6-bit two's-complement value (-32..+31). Counts above +16 act as +16 and counts below -16 act as -16.
- R8: src_sel selects the operand: 2'b00 selects acc_a, 2'b01 selects acc_b, and 2'b10 or 2'b11 selects word_in.
- R9: For a word source, a right shift gives word_out = word_in shifted right as a 16-bit value, with the top bits filled as set by R6. A left shift gives word_out = the low 16 bits of word_in shifted left.
- R10: For an accumulator source, acc_out is the full 40-bit shifted value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| src_sel | input | 2 | Operand select: 00 acc_a, 01 acc_b, 1x word_in |
| acc_a | input | 40 | First accumulator operand |
| acc_b | input | 40 | Second accumulator operand |
| word_in | input | 16 | Bus word operand |
| shift_cnt | input | 6 | Signed count: positive shifts right, negative shifts left |
| arith_right | input | 1 | 1 = sign fill, 0 = zero fill on right shifts |
| acc_out | output | 40 | Registered 40-bit datapath result |
| word_out | output | 16 | Registered 16-bit result, read from the operand's placement window |

## Verification
The bench builds the block with its default parameters: a 40-bit datapath, a 16-bit word whose right-shift window starts at bit 16, a maximum shift of 16, a 6-bit count and the staged shifter variant. Because the count is 6 bits wide, values of +31, +20, -20 and -32 can be driven, which tests the clamp on both sides. Shifts of exactly 16 move the 16-bit word completely out of its window, and a left shift with arith_right set shows that the fill select has no effect on left shifts.

// File: rtl/shbt_pkg.sv
package shbt_pkg;
   typedef enum logic [1:0] {
      SRC_ACC_A    = 2'b00,
      SRC_ACC_B    = 2'b01,
      SRC_WORD     = 2'b10,
      SRC_WORD_ALT = 2'b11
   } shbt_src_e;

   function automatic logic is_word_src(input logic [1:0] sel);
      return sel[1];
   endfunction
endpackage

// File: rtl/shbt_count_decode.sv
module shbt_count_decode #(
   parameter int CNT_W  = 6,
   parameter int MAX_SH = 16,
   parameter int MAG_W  = $clog2(MAX_SH + 1)
) (
   input  logic [CNT_W-1:0] cnt,
   output logic             dir_left,
   output logic [MAG_W-1:0] mag
);
   logic signed [CNT_W:0] ext;
   logic        [CNT_W:0] absval;

   assign ext      = {cnt[CNT_W-1], cnt};
   assign dir_left = cnt[CNT_W-1];

   always_comb begin
      if (ext < 0) absval = -ext;
      else         absval = ext;
      if (absval > (CNT_W+1)'(MAX_SH)) mag = MAG_W'(MAX_SH);
      else                             mag = absval[MAG_W-1:0];
   end
endmodule

// File: rtl/shbt_operand_place.sv
module shbt_operand_place
   import shbt_pkg::*;
#(
   parameter int ACC_W  = 40,
   parameter int WORD_W = 16,
   parameter int WIN_LO = 16
) (
   input  logic [1:0]        src_sel,
   input  logic [ACC_W-1:0]  acc_a,
   input  logic [ACC_W-1:0]  acc_b,
   input  logic [WORD_W-1:0] word_in,
   input  logic              dir_left,
   input  logic              arith_right,
   output logic [ACC_W-1:0]  operand,
   output logic              fill
);
   localparam int HI_W = ACC_W - WIN_LO - WORD_W;

   logic word_sign;
   assign word_sign = arith_right & word_in[WORD_W-1];

   always_comb begin
      if (is_word_src(src_sel)) begin
         if (dir_left) operand = {{(ACC_W-WORD_W){1'b0}}, word_in};
         else          operand = {{HI_W{word_sign}}, word_in, {WIN_LO{1'b0}}};
      end else if (src_sel[0]) begin
         operand = acc_b;
      end else begin
         operand = acc_a;
      end
      fill = arith_right & ~dir_left & operand[ACC_W-1];
   end
endmodule

// File: rtl/shbt_shift_core.sv
module shbt_shift_core #(
   parameter int ACC_W          = 40,
   parameter int MAG_W          = 5,
   parameter bit USE_LOG_STAGES = 1'b1
) (
   input  logic [ACC_W-1:0] din,
   input  logic             dir_left,
   input  logic             fill,
   input  logic [MAG_W-1:0] mag,
   output logic [ACC_W-1:0] dout
);
   generate
      if (USE_LOG_STAGES) begin : g_stages
         logic [ACC_W-1:0] stage [0:MAG_W];
         assign stage[0] = din;
         for (genvar k = 0; k < MAG_W; k++) begin : g_st
            localparam int D = 1 << k;
            if (D < ACC_W) begin : g_mv
               assign stage[k+1] = !mag[k]  ? stage[k] :
                                   dir_left ? (stage[k] << D) :
                                              {{D{fill}}, stage[k][ACC_W-1:D]};
            end else begin : g_all
               assign stage[k+1] = !mag[k] ? stage[k] :
                                   dir_left ? '0 : {ACC_W{fill}};
            end
         end
         assign dout = stage[MAG_W];
      end else begin : g_direct
         logic signed [ACC_W-1:0] sdin;
         assign sdin = din;
         always_comb begin
            if (dir_left)  dout = din << mag;
            else if (fill) dout = ACC_W'(sdin >>> mag);
            else           dout = din >> mag;
         end
      end
   endgenerate
endmodule

// File: rtl/shbt_barrel.sv
module shbt_barrel #(
   parameter int ACC_W          = 40,
   parameter int WORD_W         = 16,
   parameter int WIN_LO         = 16,
   parameter int MAX_SH         = 16,
   parameter int CNT_W          = 6,
   parameter bit USE_LOG_STAGES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        src_sel,
   input  logic [ACC_W-1:0]  acc_a,
   input  logic [ACC_W-1:0]  acc_b,
   input  logic [WORD_W-1:0] word_in,
   input  logic [CNT_W-1:0]  shift_cnt,
   input  logic              arith_right,
   output logic [ACC_W-1:0]  acc_out,
   output logic [WORD_W-1:0] word_out
);
   localparam int MAG_W = $clog2(MAX_SH + 1);

   generate
      if (WIN_LO + WORD_W > ACC_W) begin : g_bad_win
         $error("word window exceeds datapath");
      end
      if (MAX_SH >= ACC_W) begin : g_bad_max
         $error("maximum shift must be below datapath width");
      end
      if ((1 << (CNT_W - 1)) <= MAX_SH) begin : g_bad_cnt
         $error("count width cannot express the maximum shift");
      end
   endgenerate

   logic             dir_left, fill;
   logic [MAG_W-1:0] mag;
   logic [ACC_W-1:0] operand, shifted;
   logic [WORD_W-1:0] word_res;

   shbt_count_decode #(.CNT_W(CNT_W), .MAX_SH(MAX_SH), .MAG_W(MAG_W)) u_dec (
      .cnt(shift_cnt), .dir_left(dir_left), .mag(mag)
   );

   shbt_operand_place #(.ACC_W(ACC_W), .WORD_W(WORD_W), .WIN_LO(WIN_LO)) u_place (
      .src_sel(src_sel), .acc_a(acc_a), .acc_b(acc_b), .word_in(word_in),
      .dir_left(dir_left), .arith_right(arith_right),
      .operand(operand), .fill(fill)
   );

   shbt_shift_core #(.ACC_W(ACC_W), .MAG_W(MAG_W), .USE_LOG_STAGES(USE_LOG_STAGES)) u_core (
      .din(operand), .dir_left(dir_left), .fill(fill), .mag(mag), .dout(shifted)
   );

   assign word_res = dir_left ? shifted[WORD_W-1:0]
                              : shifted[WIN_LO+WORD_W-1:WIN_LO];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_out  <= '0;
         word_out <= '0;
      end else begin
         acc_out  <= shifted;
         word_out <= word_res;
      end
   end
endmodule

// File: rtl/shbt_barrel_chk.sv
module shbt_barrel_chk #(
   parameter int ACC_W  = 40,
   parameter int WORD_W = 16,
   parameter int MAX_SH = 16,
   parameter int CNT_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        src_sel,
   input logic [ACC_W-1:0]  acc_a,
   input logic [WORD_W-1:0] word_in,
   input logic [CNT_W-1:0]  shift_cnt,
   input logic              arith_right,
   input logic [ACC_W-1:0]  acc_out,
   input logic [WORD_W-1:0] word_out
);
   // R5
   zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_cnt == '0 && src_sel == 2'b00) |=> acc_out == $past(acc_a));

   // R5
   word_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_cnt == '0 && src_sel[1]) |=> word_out == $past(word_in));

   // R4
   left_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_cnt[CNT_W-1] && !src_sel[1]) |=> acc_out[0] == 1'b0);

   // R6
   logic_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_cnt[CNT_W-1] && shift_cnt != '0 && !arith_right && !src_sel[1])
      |=> acc_out[ACC_W-1] == 1'b0);

   // R6
   arith_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_cnt[CNT_W-1] && arith_right && src_sel == 2'b00)
      |=> acc_out[ACC_W-1] == $past(acc_a[ACC_W-1]));

   // R7
   clamp_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_cnt[CNT_W-1] && shift_cnt >= CNT_W'(MAX_SH) && !arith_right && src_sel == 2'b00)
      |=> acc_out[ACC_W-1 -: MAX_SH] == '0);
endmodule

bind shbt_barrel shbt_barrel_chk #(
   .ACC_W(ACC_W), .WORD_W(WORD_W), .MAX_SH(MAX_SH), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .acc_a(acc_a),
   .word_in(word_in), .shift_cnt(shift_cnt), .arith_right(arith_right),
   .acc_out(acc_out), .word_out(word_out)
);

// File: tb/shbt_barrel_test.sv
`timescale 1ns/1ps
module shbt_barrel_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  src_sel = 2'b00;
   logic [39:0] acc_a = '0, acc_b = '0;
   logic [15:0] word_in = '0;
   logic [5:0]  shift_cnt = '0;
   logic        arith_right = 1'b0;
   logic [39:0] acc_out;
   logic [15:0] word_out;

   always #2 clk = ~clk;

   shbt_barrel uut (
      .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .acc_a(acc_a), .acc_b(acc_b),
      .word_in(word_in), .shift_cnt(shift_cnt), .arith_right(arith_right),
      .acc_out(acc_out), .word_out(word_out)
   );

   typedef struct {
      logic        is_word;
      logic [39:0] acc;
      logic [15:0] wd;
      string       tag;
   } exp_t;

   exp_t sbq[$];
   int   total = 0;
   int   bad   = 0;

   task automatic drive(input logic [1:0] s, input logic [39:0] a, input logic [39:0] b,
                        input logic [15:0] w, input int c, input logic ar, input string tag);
      exp_t e;
      int n;
      logic left;
      logic [39:0] opnd;
      logic signed [39:0] sa;
      logic signed [15:0] sw;
      @(negedge clk);
      src_sel = s; acc_a = a; acc_b = b; word_in = w;
      shift_cnt = 6'(c); arith_right = ar;
      left = (c < 0);
      n = left ? -c : c;
      if (n > 16) n = 16;
      e.tag = tag;
      e.is_word = s[1];
      e.acc = '0;
      e.wd = '0;
      if (s[1]) begin
         sw = w;
         if (left)    e.wd = w << n;
         else if (ar) e.wd = 16'(sw >>> n);
         else         e.wd = w >> n;
      end else begin
         opnd = s[0] ? b : a;
         sa = opnd;
         if (left)    e.acc = opnd << n;
         else if (ar) e.acc = 40'(sa >>> n);
         else         e.acc = opnd >> n;
      end
      sbq.push_back(e);
   endtask

   always @(posedge clk) begin
      #1;
      if (rst_n && sbq.size() > 0) begin
         exp_t e;
         e = sbq.pop_front();
         total++;
         if (e.is_word) begin
            if (word_out !== e.wd) begin
               bad++;
               $display("FAIL %s word_out actual=%h expected=%h", e.tag, word_out, e.wd);
            end
         end else if (acc_out !== e.acc) begin
            bad++;
            $display("FAIL %s acc_out actual=%h expected=%h", e.tag, acc_out, e.acc);
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      acc_a = 40'hFF_FFFF_FFFF; word_in = 16'hFFFF; shift_cnt = 6'd3;
      repeat (3) @(posedge clk);
      @(negedge clk);
      total++;
      if (acc_out !== '0 || word_out !== '0) begin
         bad++;
         $display("FAIL R1 reset actual=%h/%h expected=0/0", acc_out, word_out);
      end
      rst_n = 1'b1;
      // R5 / R2 zero count passthrough
      drive(2'b00, 40'h12_3456_789A, 40'h0, 16'h0, 0, 1'b1, "R5_acc_zero");
      // R3 / R6 arithmetic right on negative value
      drive(2'b00, 40'h80_0000_00F0, 40'h0, 16'h0, 1, 1'b1, "R3_r6_arith1");
      drive(2'b00, 40'hF0_1234_5678, 40'h0, 16'h0, 5, 1'b0, "R6_logic5");
      drive(2'b00, 40'h9A_BCDE_F012, 40'h0, 16'h0, 16, 1'b1, "R3_arith16");
      // R7 clamp
      drive(2'b00, 40'hC3_5A5A_A5A5, 40'h0, 16'h0, 31, 1'b0, "R7_clamp_pos");
      drive(2'b00, 40'h00_0000_0001, 40'h0, 16'h0, -1, 1'b0, "R4_left1");
      drive(2'b00, 40'h01_2345_6789, 40'h0, 16'h0, -16, 1'b0, "R4_left16");
      drive(2'b00, 40'h01_2345_6789, 40'h0, 16'h0, -32, 1'b0, "R7_clamp_neg");
      drive(2'b00, 40'h00_0000_00FF, 40'h0, 16'h0, -20, 1'b0, "R7_clamp_m20");
      // R6 arith_right ignored on left shift
      drive(2'b00, 40'hFF_0000_0003, 40'h0, 16'h0, -4, 1'b1, "R6_left_ignore");
      // R8 / R10 second accumulator
      drive(2'b01, 40'h11_1111_1111, 40'h80_0000_0008, 16'h0, 3, 1'b1, "R8_accb_right");
      drive(2'b01, 40'h0, 40'h0F_F000_000F, 16'h0, -7, 1'b0, "R10_accb_left");
      // R9 word operand
      drive(2'b10, 40'h0, 40'h0, 16'h8001, 4, 1'b1, "R9_word_arith");
      drive(2'b10, 40'h0, 40'h0, 16'h8001, 4, 1'b0, "R9_word_logic");
      drive(2'b10, 40'h0, 40'h0, 16'hF00F, -4, 1'b1, "R9_word_left");
      drive(2'b10, 40'h0, 40'h0, 16'hBEEF, 0, 1'b0, "R5_word_zero");
      drive(2'b10, 40'h0, 40'h0, 16'hA000, 20, 1'b1, "R7_word_clamp");
      drive(2'b10, 40'h0, 40'h0, 16'h1234, 16, 1'b0, "R9_word_out16");
      drive(2'b10, 40'h0, 40'h0, 16'hFFFF, -16, 1'b0, "R9_word_left16");
      drive(2'b11, 40'hFF_FFFF_FFFF, 40'h0, 16'h7F00, 2, 1'b1, "R8_word_alt");
      repeat (3) @(posedge clk);
      #2;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule